// File: doc/BRIEF.md
# I2C Protocol Trigger

This block decodes a two-wire serial bus from a sampled logic analyzer capture stream and fires a trigger on protocol content. Two of the sampled channels are picked at run time. One is the data line and the other the clock line. The block watches each accepted sample against the previous accepted one. From that comparison it reports bus start and stop conditions, assembles data bytes, and reports the acknowledge bit that follows each byte.

The first byte of every frame carries the address and direction bit. It is compared against a programmed value under a bit mask. A match raises a one-cycle trigger strobe, and a trigger output then stays high for a fixed number of cycles. The trigger can fire as soon as the byte completes. Optionally it waits until the acknowledge slot shows the bus acknowledged the byte. The block never drives the bus; it only observes the samples.

Top module: `i2c_proto_trig`

## Requirements
- R1: When, between two consecutive accepted samples, the data line goes from 1 to 0 and the clock line is 1 in both, `start_flag` is high for exactly the one cycle after the clock edge that accepted the second sample.
- R2: When, between two consecutive accepted samples, the data line goes from 0 to 1 and the clock line is 1 in both, `stop_flag` is high for exactly the one cycle after that edge.
- R3: When the data line and the clock line both change between two consecutive accepted samples, neither `start_flag` nor `stop_flag` is raised.
- R4: `sda_sel` picks the data channel and `scl_sel` picks the clock channel (channel n is bit n of `smp_data`). The levels of all other channels have no effect on any output.
- R5: A cycle with `smp_valid` low is ignored entirely. Edge detection compares each accepted sample with the previous accepted one.
- R6: Inside a frame, the data line level at each clock-line rising edge is shifted in most significant bit first. On the 8th such edge, `byte_rdy` pulses for one cycle and `byte_out` shows the byte; `byte_out` holds until the next byte.
- R7: The 9th clock-line rising edge of a frame slot is the acknowledge bit. It pulses `ack_rdy` for one cycle and never `byte_rdy`. `ack_nack` shows the data line level at that edge (0 = acknowledged, 1 = not acknowledged), and the next slot starts again with a most significant bit.
- R8: A start seen part way through a byte (repeated start) discards the partial bits. The next 8 clock rising edges form a complete new first byte.
- R9: A stop discards any partial byte and ends the frame. Clock rising edges outside a frame produce no `byte_rdy` and no `ack_rdy`.
- R10: With `need_ack` low, `trig` pulses for one cycle in the cycle after `byte_rdy` of the first byte of a frame when `((byte ^ match_val) & match_mask) == 0`; a mask bit of 1 means that bit is compared. Later bytes of the frame never trigger.
- R11: With `need_ack` high, a matching first byte triggers only at its acknowledge bit. `trig` pulses in the cycle after `ack_rdy` when `ack_nack` is 0, and no trigger comes when it is 1.
- R12: `trig_out` goes high in the cycle after `trig` and stays high for exactly PULSE_CYC cycles (default 6). A new `trig` restarts the count.
- R13: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | High when `smp_data` holds a sample to accept |
| smp_data | input | CHANNELS | Sampled channel levels |
| sda_sel | input | clog2(CHANNELS) | Index of the data-line channel |
| scl_sel | input | clog2(CHANNELS) | Index of the clock-line channel |
| match_val | input | DATA_W | Address byte value to match |
| match_mask | input | DATA_W | Bits set here take part in the compare |
| need_ack | input | 1 | Trigger only once the matched byte is acknowledged |
| start_flag | output | 1 | Start condition seen |
| stop_flag | output | 1 | Stop condition seen |
| byte_rdy | output | 1 | One-cycle strobe: `byte_out` holds a new byte |
| byte_out | output | DATA_W | Last received byte |
| ack_rdy | output | 1 | One-cycle strobe: acknowledge bit received |
| ack_nack | output | 1 | Last acknowledge level, 1 = not acknowledged |
| trig | output | 1 | One-cycle trigger strobe |
| trig_out | output | 1 | Stretched trigger pulse |

## Verification
The hardest state to reach from the ports is a first byte that matches the masked address while the acknowledge-gated option is on. Reaching it also needs a not-acknowledge, and it must happen after an interrupted byte or with invalid samples carrying clashing garbage in between. The random transactions reach it on purpose. They build the address from the match value with only unmasked bits flipped, then pick the acknowledge level, repeated starts, gaps and channel selections at random. A bench reference model follows every sample. Directed cases pin down simultaneous edges, a stop inside a byte and the pulse length.

// File: rtl/i2c_trig_pkg.sv
package i2c_trig_pkg;
   // Line events derived from one accepted sample
   typedef struct packed {
      logic start;   // data falls, clock held high
      logic stop;    // data rises, clock held high
      logic rise;    // clock rising edge
      logic sda;     // data level in this sample
   } line_ev_t;
endpackage

// File: rtl/i2c_line_sel.sv
module i2c_line_sel
   import i2c_trig_pkg::*;
#(
   parameter int CHANNELS = 16,
   localparam int SEL_W = $clog2(CHANNELS)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [CHANNELS-1:0] smp_data,
   input  logic [SEL_W-1:0]    sda_sel,
   input  logic [SEL_W-1:0]    scl_sel,
   output line_ev_t            ev
);
   logic cur_sda, cur_scl;
   logic prev_sda, prev_scl, have_prev;

   generate
      if ((1 << SEL_W) == CHANNELS) begin : g_pow2
         assign cur_sda = smp_data[sda_sel];
         assign cur_scl = smp_data[scl_sel];
      end else begin : g_guard
         assign cur_sda = (32'(sda_sel) < CHANNELS) ? smp_data[sda_sel] : 1'b0;
         assign cur_scl = (32'(scl_sel) < CHANNELS) ? smp_data[scl_sel] : 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sda  <= 1'b0;
         prev_scl  <= 1'b0;
         have_prev <= 1'b0;
      end else if (smp_valid) begin
         prev_sda  <= cur_sda;
         prev_scl  <= cur_scl;
         have_prev <= 1'b1;
      end
   end

   logic acc, scl_hold;
   assign acc      = smp_valid & have_prev;
   assign scl_hold = prev_scl & cur_scl;

   always_comb begin
      ev.start = acc & scl_hold & prev_sda & ~cur_sda;
      ev.stop  = acc & scl_hold & ~prev_sda & cur_sda;
      ev.rise  = acc & ~prev_scl & cur_scl;
      ev.sda   = cur_sda;
   end
endmodule

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx
   import i2c_trig_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev,
   output logic              start_flag,
   output logic              stop_flag,
   output logic              byte_rdy,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_first,
   output logic              ack_rdy,
   output logic              ack_nack
);
   logic              in_frame, first;
   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shifted;

   assign shifted = {shreg[DATA_W-2:0], ev.sda};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_flag <= 1'b0;
         stop_flag  <= 1'b0;
         byte_rdy   <= 1'b0;
         byte_out   <= '0;
         byte_first <= 1'b0;
         ack_rdy    <= 1'b0;
         ack_nack   <= 1'b0;
         in_frame   <= 1'b0;
         first      <= 1'b0;
         bit_cnt    <= '0;
         shreg      <= '0;
      end else begin
         start_flag <= ev.start;
         stop_flag  <= ev.stop;
         byte_rdy   <= 1'b0;
         ack_rdy    <= 1'b0;
         if (ev.start) begin
            in_frame <= 1'b1;
            first    <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
         end else if (ev.stop) begin
            in_frame <= 1'b0;
            first    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
         end else if (ev.rise && in_frame) begin
            if (bit_cnt == CNT_W'(DATA_W)) begin
               ack_rdy  <= 1'b1;
               ack_nack <= ev.sda;
               bit_cnt  <= '0;
               first    <= 1'b0;
            end else begin
               shreg   <= shifted;
               bit_cnt <= bit_cnt + CNT_W'(1);
               if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                  byte_rdy   <= 1'b1;
                  byte_out   <= shifted;
                  byte_first <= first;
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_match.sv
module i2c_match #(
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 6,
   localparam int CW = $clog2(PULSE_CYC + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_rdy,
   input  logic              byte_first,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              ack_rdy,
   input  logic              ack_nack,
   input  logic              frame_reset,
   input  logic [DATA_W-1:0] match_val,
   input  logic [DATA_W-1:0] match_mask,
   input  logic              need_ack,
   output logic              trig,
   output logic              trig_out
);
   logic hit, pend;
   assign hit = ((byte_in ^ match_val) & match_mask) == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig <= 1'b0;
         pend <= 1'b0;
      end else begin
         trig <= 1'b0;
         if (byte_rdy && byte_first) begin
            if (need_ack) pend <= hit;
            else          trig <= hit;
         end
         if (ack_rdy) begin
            if (pend && !ack_nack) trig <= 1'b1;
            pend <= 1'b0;
         end
         if (frame_reset) pend <= 1'b0;
      end
   end

   generate
      if (PULSE_CYC == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) trig_out <= 1'b0;
            else        trig_out <= trig;
         end
      end else begin : g_stretch
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          cnt <= '0;
            else if (trig)       cnt <= CW'(PULSE_CYC);
            else if (cnt != '0)  cnt <= cnt - CW'(1);
         end
         assign trig_out = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/i2c_proto_trig.sv
module i2c_proto_trig
   import i2c_trig_pkg::*;
#(
   parameter int CHANNELS  = 16,
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 6
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         smp_valid,
   input  logic [CHANNELS-1:0]          smp_data,
   input  logic [$clog2(CHANNELS)-1:0]  sda_sel,
   input  logic [$clog2(CHANNELS)-1:0]  scl_sel,
   input  logic [DATA_W-1:0]            match_val,
   input  logic [DATA_W-1:0]            match_mask,
   input  logic                         need_ack,
   output logic                         start_flag,
   output logic                         stop_flag,
   output logic                         byte_rdy,
   output logic [DATA_W-1:0]            byte_out,
   output logic                         ack_rdy,
   output logic                         ack_nack,
   output logic                         trig,
   output logic                         trig_out
);
   generate
      if (CHANNELS < 2) begin : g_bad_ch
         $error("CHANNELS must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("DATA_W must be at least 2");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC must be at least 1");
      end
   endgenerate

   line_ev_t ev;
   logic     byte_first;

   i2c_line_sel #(.CHANNELS(CHANNELS)) u_sel (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .sda_sel(sda_sel), .scl_sel(scl_sel), .ev(ev)
   );

   i2c_frame_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .ev(ev),
      .start_flag(start_flag), .stop_flag(stop_flag),
      .byte_rdy(byte_rdy), .byte_out(byte_out), .byte_first(byte_first),
      .ack_rdy(ack_rdy), .ack_nack(ack_nack)
   );

   i2c_match #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) u_match (
      .clk(clk), .rst_n(rst_n), .byte_rdy(byte_rdy), .byte_first(byte_first),
      .byte_in(byte_out), .ack_rdy(ack_rdy), .ack_nack(ack_nack),
      .frame_reset(start_flag | stop_flag),
      .match_val(match_val), .match_mask(match_mask), .need_ack(need_ack),
      .trig(trig), .trig_out(trig_out)
   );
endmodule

// File: rtl/i2c_proto_trig_chk.sv
module i2c_proto_trig_chk (
   input logic clk,
   input logic rst_n,
   input logic smp_valid,
   input logic start_flag,
   input logic stop_flag,
   input logic byte_rdy,
   input logic ack_rdy,
   input logic ack_nack,
   input logic trig,
   input logic trig_out
);
   AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_flag && stop_flag));                                          // R3
   AST_EVENT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (start_flag || stop_flag || byte_rdy || ack_rdy) |-> $past(smp_valid)); // R5
   AST_BYTE_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_rdy && ack_rdy));                                              // R7
   AST_TRIG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> ($past(byte_rdy) || $past(ack_rdy)));                        // R10
   AST_TRIG_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && $past(ack_rdy)) |-> !$past(ack_nack));                       // R11
   AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_out) |-> $past(trig));                                     // R12
   AST_PULSE_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> trig_out);                                                   // R12
endmodule

bind i2c_proto_trig i2c_proto_trig_chk u_chk (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
   .start_flag(start_flag), .stop_flag(stop_flag),
   .byte_rdy(byte_rdy), .ack_rdy(ack_rdy), .ack_nack(ack_nack),
   .trig(trig), .trig_out(trig_out)
);

// File: tb/i2c_proto_trig_tb.sv
module i2c_proto_trig_tb;
   localparam int CH = 16;
   localparam int DW = 8;
   localparam int PC = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [CH-1:0] smp_data = '0;
   logic [3:0]    sda_sel = 4'd0, scl_sel = 4'd1;
   logic [DW-1:0] match_val = '0, match_mask = '0;
   logic          need_ack = 1'b0;
   logic          start_flag, stop_flag, byte_rdy, ack_rdy, ack_nack, trig, trig_out;
   logic [DW-1:0] byte_out;

   always #4 clk = ~clk;

   i2c_proto_trig #(.CHANNELS(CH), .DATA_W(DW), .PULSE_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .sda_sel(sda_sel), .scl_sel(scl_sel), .match_val(match_val),
      .match_mask(match_mask), .need_ack(need_ack),
      .start_flag(start_flag), .stop_flag(stop_flag), .byte_rdy(byte_rdy),
      .byte_out(byte_out), .ack_rdy(ack_rdy), .ack_nack(ack_nack),
      .trig(trig), .trig_out(trig_out)
   );

   int n_chk = 0, n_fail = 0;
   int n_start = 0, n_stop = 0, n_byte = 0, n_ack = 0, n_trig = 0, n_to = 0;
   logic [DW-1:0] last_byte = '0;
   int gap_pct = 0;

   // reference model state
   logic m_have = 0, m_psda = 0, m_pscl = 0, m_in = 0, m_first = 0, m_pend = 0;
   int   m_bits = 0, m_cnt = 0;
   logic [DW-1:0] m_sh = '0;
   logic o_start = 0, o_stop = 0, o_brdy = 0, o_first = 0, o_ardy = 0, o_nack = 0, o_trig = 0;
   logic [DW-1:0] o_byte = '0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic step(input logic sda, input logic scl, input logic valid);
      logic [CH-1:0] d;
      logic ev_s, ev_p, rise, n_trig_m, hit;
      d = CH'($urandom);
      if (valid) begin
         d[sda_sel] = sda;
         d[scl_sel] = scl;
      end
      smp_valid = valid;
      smp_data  = d;
      ev_s = valid & m_have & m_psda & !sda & m_pscl & scl;
      ev_p = valid & m_have & !m_psda & sda & m_pscl & scl;
      rise = valid & m_have & !m_pscl & scl;
      if (valid) begin m_have = 1; m_psda = sda; m_pscl = scl; end
      // match stage from previously visible outputs
      n_trig_m = 0;
      if (o_brdy && o_first) begin
         hit = ((o_byte ^ match_val) & match_mask) == '0;
         if (need_ack) m_pend = hit; else n_trig_m = hit;
      end
      if (o_ardy) begin
         if (m_pend && !o_nack) n_trig_m = 1;
         m_pend = 0;
      end
      if (o_start || o_stop) m_pend = 0;
      m_cnt = o_trig ? PC : (m_cnt != 0 ? m_cnt - 1 : 0);
      o_trig = n_trig_m;
      // frame stage
      o_start = ev_s; o_stop = ev_p; o_brdy = 0; o_ardy = 0;
      if (ev_s) begin m_in = 1; m_bits = 0; m_sh = '0; m_first = 1; end
      else if (ev_p) begin m_in = 0; m_bits = 0; m_sh = '0; m_first = 0; end
      else if (rise && m_in) begin
         if (m_bits == DW) begin o_ardy = 1; o_nack = sda; m_bits = 0; m_first = 0; end
         else begin
            m_sh = {m_sh[DW-2:0], sda};
            m_bits++;
            if (m_bits == DW) begin o_brdy = 1; o_byte = m_sh; o_first = m_first; end
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk("R1 start_flag", 32'(start_flag), 32'(o_start));
      chk("R2 stop_flag", 32'(stop_flag), 32'(o_stop));
      chk("R6 byte_rdy", 32'(byte_rdy), 32'(o_brdy));
      chk("R6 byte_out", 32'(byte_out), 32'(o_byte));
      chk("R7 ack_rdy", 32'(ack_rdy), 32'(o_ardy));
      chk("R7 ack_nack", 32'(ack_nack), 32'(o_nack));
      chk("R10 trig", 32'(trig), 32'(o_trig));
      chk("R12 trig_out", 32'(trig_out), 32'(m_cnt != 0));
      n_start += int'(start_flag); n_stop += int'(stop_flag);
      n_ack += int'(ack_rdy); n_trig += int'(trig); n_to += int'(trig_out);
      if (byte_rdy) begin n_byte++; last_byte = byte_out; end
   endtask

   task automatic s(input logic sda, input logic scl);
      if (gap_pct != 0 && ($urandom % 100) < gap_pct) step(1'b0, 1'b0, 1'b0);
      step(sda, scl, 1'b1);
   endtask

   task automatic do_start();  s(1,0); s(1,1); s(0,1); s(0,0); endtask
   task automatic do_stop();   s(0,0); s(0,1); s(1,1); endtask
   task automatic do_bit(input logic b); s(b,0); s(b,1); s(b,1); s(b,0); endtask
   task automatic send_byte(input logic [DW-1:0] b, input logic ack);
      for (int i = DW - 1; i >= 0; i--) do_bit(b[i]);
      do_bit(ack);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) s(1,1);
   endtask

   initial begin
      int b0, t0, k0;
      logic [DW-1:0] a;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R13: reset state
      chk("R13 outputs in reset", {24'd0, start_flag, stop_flag, byte_rdy, ack_rdy,
          ack_nack, trig, trig_out, |byte_out}, 32'd0);
      rst_n = 1'b1;
      idle(3);

      // R3: data and clock change in the same sample
      b0 = n_start;
      s(1,0); s(0,1);
      chk("R3 no start on simultaneous change", 32'(n_start - b0), 0);
      s(0,0); idle(2);

      // R4: fixed selection, byte through noisy channels
      sda_sel = 4'd3; scl_sel = 4'd12;
      do_start(); send_byte(8'h3C, 0); do_stop(); idle(2);
      chk("R4 byte on selected channels", 32'(last_byte), 32'h3C);

      // R5: many invalid garbage samples between valid ones
      gap_pct = 70;
      b0 = n_byte;
      do_start(); send_byte(8'hC3, 1); do_stop(); idle(2);
      chk("R5 byte count with gaps", 32'(n_byte - b0), 1);
      chk("R5 byte value with gaps", 32'(last_byte), 32'hC3);
      gap_pct = 0;

      // R8: repeated start mid-byte
      b0 = n_byte;
      do_start(); for (int i = 0; i < 5; i++) do_bit(1'b0);
      do_start(); send_byte(8'hA5, 0); do_stop(); idle(2);
      chk("R8 single byte after restart", 32'(n_byte - b0), 1);
      chk("R8 byte value after restart", 32'(last_byte), 32'hA5);

      // R9: stop mid-byte then clocks outside a frame
      b0 = n_byte; k0 = n_ack;
      do_start(); do_bit(1); do_bit(0); do_bit(1); do_stop();
      for (int i = 0; i < 12; i++) do_bit(i[0]);
      idle(2);
      chk("R9 no byte outside frame", 32'(n_byte - b0), 0);
      chk("R9 no ack outside frame", 32'(n_ack - k0), 0);

      // R10: masked match, only the first byte triggers
      match_val = 8'hA0; match_mask = 8'hF0; need_ack = 0;
      t0 = n_trig; k0 = n_to;
      do_start(); send_byte(8'hA7, 1); send_byte(8'hA7, 1); do_stop(); idle(PC + 3);
      chk("R10 one trigger per frame", 32'(n_trig - t0), 1);
      chk("R12 trig_out length", 32'(n_to - k0), PC);
      t0 = n_trig;
      do_start(); send_byte(8'hB7, 0); do_stop(); idle(2);
      chk("R10 masked mismatch", 32'(n_trig - t0), 0);

      // R11: acknowledge-gated trigger
      need_ack = 1;
      t0 = n_trig;
      do_start(); send_byte(8'hA1, 1); do_stop(); idle(2);
      chk("R11 nack blocks trigger", 32'(n_trig - t0), 0);
      do_start(); send_byte(8'hA1, 0); do_stop(); idle(PC + 2);
      chk("R11 ack allows trigger", 32'(n_trig - t0), 1);

      // constrained random transactions
      for (int t = 0; t < 60; t++) begin
         sda_sel = 4'($urandom);
         scl_sel = sda_sel + 4'(1 + $urandom % 15);
         need_ack = 1'($urandom);
         match_val = DW'($urandom);
         match_mask = DW'($urandom);
         gap_pct = ($urandom % 3 == 0) ? 40 : 0;
         idle(2);
         a = ($urandom % 3 != 0) ? (match_val ^ (DW'($urandom) & ~match_mask)) : DW'($urandom);
         do_start();
         if ($urandom % 4 == 0) begin
            for (int i = 0; i < int'($urandom % 8); i++) do_bit(1'($urandom));
            do_start();
         end
         send_byte(a, 1'($urandom));
         if ($urandom % 2 == 1) send_byte(DW'($urandom), 1'($urandom));
         if ($urandom % 5 == 0) for (int i = 0; i < 3; i++) do_bit(1'($urandom));
         do_stop();
         idle(int'($urandom % 4));
      end
      gap_pct = 0;
      idle(PC + 3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule